// File: doc/BRIEF.md
# Sequential Restoring Integer Divider

This block divides one 32-bit integer by another over a fixed number of clock cycles. A caller places the dividend, the divisor and a signed/unsigned select on the inputs and pulses `start` while the block is idle. The block captures the operands and then runs one restoring step per cycle. When it finishes it raises `done` for a single cycle. The quotient and remainder then stay on the outputs until the next accepted start.

The datapath has a divisor register, one subtractor and a double-width working register. The low half of the working register collects quotient bits as the register shifts left. It shifts once before the first trial subtraction. Each step tests whether the divisor fits into the upper half. If it does not, the upper half keeps its old value and a 0 enters the low end. If it does, the difference replaces the upper half and a 1 enters the low end. After the last step the upper half is read one bit to the right, which gives the true remainder.

In signed mode the block works on magnitudes. It negates the quotient when the operand signs differ, and it gives the remainder the sign of the dividend.

Top module: `seq_divider`

## Requirements
- R1: After reset, `busy` and `done` are both 0.
- R2: A `start` seen while idle makes `busy` 1 from the next cycle. `done` goes high in the cycle after exactly 32 further clock edges, so it can first be seen 32 negative edges after the accepting edge.
- R3: Unsigned mode (`is_signed`=0) returns quotient = floor(dividend/divisor) and remainder = dividend − quotient·divisor, with remainder < divisor. In a 4-bit view, 7/2 gives 0011 and 0001.
- R4: Signed mode (`is_signed`=1) returns the two's-complement quotient truncated toward zero. It is negated when the operand signs differ, so −7/2 gives −3 and −7/−2 gives 3.
- R5: In signed mode the remainder is zero or has the dividend's sign, and its magnitude is below the divisor's magnitude. −7/2 and −7/−2 both leave −1.
- R6: A zero divisor takes the normal step count and returns an all-ones quotient, with the remainder equal to the dividend, in either mode.
- R7: In signed mode, 0x80000000 divided by −1 returns quotient 0x80000000 and remainder 0.
- R8: `done` is high for exactly one cycle. The quotient and remainder hold their values after it until the next accepted start.
- R9: While `busy` is 1, `start` and any change on the operand inputs have no effect on the run in progress or on its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request a division; accepted only when idle |
| is_signed | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| dividend | input | 32 | Number to be divided |
| divisor | input | 32 | Number to divide by |
| busy | output | 1 | A division is in progress |
| done | output | 1 | One-cycle pulse when the result is ready |
| quotient | output | 32 | Quotient of the last completed division |
| remainder | output | 32 | Remainder of the last completed division |

## Verification
The bench goes after divisors with the top bit set in unsigned mode. There the shifted upper half exceeds 32 bits, and a working register without its extra bit would return wrong quotients. It covers every sign pairing in signed mode. A missing negation, or a remainder that follows the divisor's sign, would show up as a wrong sign. A zero divisor must still finish in 32 steps with an all-ones quotient. A design that negated on sign mismatch would return 1 here instead, and one with an open-ended loop would hang. The bench also pulses start with fresh operands in the middle of a run, which catches a design that reloads while busy.

// File: rtl/div_pkg.sv
// Package: shared types for the sequential divider.
// Assumes nothing beyond a two-state control sequence.
package div_pkg;
    typedef enum logic {
        DIV_IDLE = 1'b0,
        DIV_RUN  = 1'b1
    } div_state_t;
endpackage

// File: rtl/div_operand_prep.sv
// Module: converts raw operands into magnitudes and sign flags.
// Assumes two's-complement inputs when is_signed is set; the magnitude
// of the most negative value is represented correctly as an unsigned W-bit word.
module div_operand_prep #(
    parameter int W = 32
) (
    input  logic         is_signed,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] dvd_mag,
    output logic [W-1:0] dvs_mag,
    output logic         dvd_neg,
    output logic         dvs_neg
);
    // Purpose: pick operand signs and take absolute values in signed mode.
    always_comb begin
        dvd_neg = is_signed & dividend[W-1];
        dvs_neg = is_signed & divisor[W-1];
        dvd_mag = dvd_neg ? (~dividend + 1'b1) : dividend;
        dvs_mag = dvs_neg ? (~divisor + 1'b1) : divisor;
    end
endmodule

// File: rtl/div_restore_core.sv
// Module: unsigned shift-first restoring division over W steps.
// A (2W+1)-bit working register holds the partial remainder in its upper
// W+1 bits and collects quotient bits in its lower W bits. Assumes start
// is only honoured while idle; operands are captured on acceptance.
module div_restore_core
    import div_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dvd_mag,
    input  logic [W-1:0] dvs_mag,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quo_mag,
    output logic [W-1:0] rem_mag
);
    localparam int STEPS = W;
    localparam int CW    = $clog2(STEPS + 1);
    localparam int AW    = 2 * W + 1;

    div_state_t      state_q;
    logic [AW-1:0]   acc_q;
    logic [W-1:0]    dvs_q;
    logic [CW-1:0]   step_q;
    logic            done_q;

    logic [W:0]      upper;
    logic            no_fit;
    logic [W-1:0]    trial;
    logic [W-1:0]    new_upper;
    logic [AW-1:0]   acc_step;
    logic            last_step;

    // Purpose: one trial subtraction and the shifted register for this step.
    always_comb begin
        upper     = acc_q[AW-1:W];
        no_fit    = upper < {1'b0, dvs_q};
        trial     = upper[W-1:0] - dvs_q;
        new_upper = no_fit ? upper[W-1:0] : trial;
        acc_step  = {new_upper, acc_q[W-1:0], ~no_fit};
        last_step = step_q == CW'(STEPS - 1);
    end

    // Purpose: sequence load, W steps and the one-cycle completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DIV_IDLE;
            acc_q   <= '0;
            dvs_q   <= '0;
            step_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                DIV_IDLE: begin
                    if (start) begin
                        acc_q   <= {{W{1'b0}}, dvd_mag, 1'b0};
                        dvs_q   <= dvs_mag;
                        step_q  <= '0;
                        state_q <= DIV_RUN;
                    end
                end
                DIV_RUN: begin
                    acc_q  <= acc_step;
                    step_q <= step_q + 1'b1;
                    if (last_step) begin
                        state_q <= DIV_IDLE;
                        done_q  <= 1'b1;
                    end
                end
                default: state_q <= DIV_IDLE;
            endcase
        end
    end

    assign busy    = state_q == DIV_RUN;
    assign done    = done_q;
    assign quo_mag = acc_q[W-1:0];
    assign rem_mag = acc_q[AW-1:W+1];

    // R2: an idle start leads to a busy cycle next.
    assert_start_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    // R2: the step counter never passes the step count while running.
    assert_step_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (step_q < CW'(STEPS)));
    // R8: completion is a single-cycle pulse and never overlaps a run.
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R9: the captured divisor is untouched while a run is in progress.
    assert_divisor_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(dvs_q));
endmodule

// File: rtl/div_result_fix.sv
// Module: applies signs to the unsigned quotient and remainder.
// Assumes the flags were captured with the operands. A zero divisor keeps
// the all-ones quotient unchanged; the remainder follows the dividend's sign.
module div_result_fix #(
    parameter int W = 32
) (
    input  logic [W-1:0] quo_mag,
    input  logic [W-1:0] rem_mag,
    input  logic         dvd_neg,
    input  logic         dvs_neg,
    input  logic         dvs_zero,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder
);
    logic flip_q;

    // Purpose: negate quotient on sign mismatch and remainder on negative dividend.
    always_comb begin
        flip_q    = (dvd_neg ^ dvs_neg) & ~dvs_zero;
        quotient  = flip_q  ? (~quo_mag + 1'b1) : quo_mag;
        remainder = dvd_neg ? (~rem_mag + 1'b1) : rem_mag;
    end
endmodule

// File: rtl/seq_divider.sv
// Module: top of the multi-cycle signed/unsigned divider.
// Assumes start is a level sampled on rising edges; it is accepted only when
// busy is low. Outputs are valid from the done pulse until the next accepted start.
module seq_divider #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         is_signed,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder
);
    logic [W-1:0] dvd_mag, dvs_mag, quo_mag, rem_mag;
    logic         dvd_neg, dvs_neg;
    logic         dvd_neg_q, dvs_neg_q, dvs_zero_q, signed_q;
    logic         accept;

    assign accept = start & ~busy;

    div_operand_prep #(.W(W)) u_prep (
        .is_signed (is_signed),
        .dividend  (dividend),
        .divisor   (divisor),
        .dvd_mag   (dvd_mag),
        .dvs_mag   (dvs_mag),
        .dvd_neg   (dvd_neg),
        .dvs_neg   (dvs_neg)
    );

    div_restore_core #(.W(W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .dvd_mag (dvd_mag),
        .dvs_mag (dvs_mag),
        .busy    (busy),
        .done    (done),
        .quo_mag (quo_mag),
        .rem_mag (rem_mag)
    );

    // Purpose: hold the sign and zero-divisor flags of the accepted operands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dvd_neg_q  <= 1'b0;
            dvs_neg_q  <= 1'b0;
            dvs_zero_q <= 1'b0;
            signed_q   <= 1'b0;
        end else if (accept) begin
            dvd_neg_q  <= dvd_neg;
            dvs_neg_q  <= dvs_neg;
            dvs_zero_q <= divisor == '0;
            signed_q   <= is_signed;
        end
    end

    div_result_fix #(.W(W)) u_fix (
        .quo_mag   (quo_mag),
        .rem_mag   (rem_mag),
        .dvd_neg   (dvd_neg_q),
        .dvs_neg   (dvs_neg_q),
        .dvs_zero  (dvs_zero_q),
        .quotient  (quotient),
        .remainder (remainder)
    );

    // R1: nothing is in flight or completing straight after reset.
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done));
    // R6: a zero divisor completes with an all-ones quotient.
    assert_div_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && dvs_zero_q) |-> (quotient == '1));
    // R5: a nonzero signed remainder carries the dividend's sign.
    assert_rem_sign_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && signed_q && remainder != '0) |-> (remainder[W-1] == dvd_neg_q));
    // R8: results hold while idle and no new start is accepted.
    assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(quotient) && $stable(remainder)));
endmodule

// File: tb/test_seq_divider.sv
module test_seq_divider;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         is_signed = 1'b0;
    logic [W-1:0] dividend = '0;
    logic [W-1:0] divisor = '0;
    logic         busy, done;
    logic [W-1:0] quotient, remainder;

    int checks = 0;
    int errors = 0;

    seq_divider #(.W(W)) i_seq_divider (
        .clk (clk), .rst_n (rst_n), .start (start), .is_signed (is_signed),
        .dividend (dividend), .divisor (divisor), .busy (busy), .done (done),
        .quotient (quotient), .remainder (remainder)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] ref_quo(input logic [W-1:0] a, input logic [W-1:0] b, input bit s);
        longint sa, sb;
        if (b == 0) return '1;
        if (s) begin
            sa = longint'($signed(a)); sb = longint'($signed(b));
            return W'(sa / sb);
        end
        return W'(longint'(a) / longint'(b));
    endfunction

    function automatic logic [W-1:0] ref_rem(input logic [W-1:0] a, input logic [W-1:0] b, input bit s);
        longint sa, sb;
        if (b == 0) return a;
        if (s) begin
            sa = longint'($signed(a)); sb = longint'($signed(b));
            return W'(sa % sb);
        end
        return W'(longint'(a) % longint'(b));
    endfunction

    // Runs one division; optionally pulses start mid-run with other operands.
    task automatic run_div(input logic [W-1:0] a, input logic [W-1:0] b, input bit s,
                           input string req, input bit poke, input bit full);
        int cycles;
        logic [W-1:0] eq, er;
        eq = ref_quo(a, b, s);
        er = ref_rem(a, b, s);
        @(negedge clk);
        dividend = a; divisor = b; is_signed = s; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        dividend = $urandom; divisor = $urandom; is_signed = ~s;
        if (full) check(busy === 1'b1, "R2 busy after start", longint'(busy), 1);
        cycles = 0;
        while (done !== 1'b1 && cycles < 100) begin
            if (poke && cycles == 5) begin
                start = 1'b1;
                dividend = ~a; divisor = b + 1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cycles++;
        end
        start = 1'b0;
        if (full) check(cycles == 32, {req, " R2 latency"}, longint'(cycles), 32);
        check(quotient === eq, {req, " quotient"}, longint'(quotient), longint'(eq));
        check(remainder === er, {req, " remainder"}, longint'(remainder), longint'(er));
        if (full) begin
            @(negedge clk);
            check(done === 1'b0, "R8 done one cycle", longint'(done), 0);
            check(quotient === eq && remainder === er, "R8 result held",
                  longint'(quotient), longint'(eq));
        end
    endtask

    initial begin
        #(200000 * 20);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(busy === 1'b0 && done === 1'b0, "R1 reset idle", longint'({busy, done}), 0);
        rst_n = 1'b1;

        run_div(32'd7, 32'd2, 1'b0, "R3 7/2", 1'b0, 1'b1);
        run_div(32'hFFFF_FFFF, 32'h8000_0001, 1'b0, "R3 big divisor", 1'b0, 1'b1);
        run_div(32'h1234_5678, 32'hFFFF_FFFF, 1'b0, "R3 max divisor", 1'b0, 1'b0);
        run_div(-32'sd7, 32'sd2, 1'b1, "R4 R5 -7/2", 1'b0, 1'b1);
        run_div(-32'sd7, -32'sd2, 1'b1, "R4 R5 -7/-2", 1'b0, 1'b1);
        run_div(32'sd7, -32'sd2, 1'b1, "R4 R5 7/-2", 1'b0, 1'b0);
        run_div(32'h8000_0000, 32'h0000_0003, 1'b1, "R4 R5 min/3", 1'b0, 1'b0);
        run_div(32'hDEAD_BEEF, 32'd0, 1'b0, "R6 zero unsigned", 1'b0, 1'b1);
        run_div(-32'sd9, 32'd0, 1'b1, "R6 zero signed", 1'b0, 1'b1);
        run_div(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, "R7 min/-1", 1'b0, 1'b1);
        run_div(32'd1000, 32'd7, 1'b0, "R9 start ignored", 1'b1, 1'b1);
        run_div(-32'sd1000, 32'd7, 1'b1, "R9 start ignored signed", 1'b1, 1'b0);

        for (int i = 0; i < 200; i++) begin
            logic [W-1:0] a, b;
            bit s;
            a = $urandom;
            b = $urandom;
            s = 1'($urandom);
            case ($urandom % 4)
                0: b = b >> ($urandom % 32);
                1: b = b | 32'h8000_0000;
                default: ;
            endcase
            if (s) run_div(a, b, s, "R4 R5 random", 1'b0, 1'b0);
            else   run_div(a, b, s, "R3 random", 1'b0, 1'b0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule